// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a fast reference clock into a slow output whose average rate may sit between two integer division ratios. It runs two integer dividers, A and B, one after the other: it issues a programmed number of output periods of divisor A, then a programmed number of output periods of divisor B, and repeats that pattern. The average output rate over one pattern is the input rate times (RA + RB) / (DA·RA + DB·RB), where DA and DB are the divisors and RA and RB the repetition counts.

A mode input picks single operation, where only divisor A is used and every period has the same length, or dual operation with the alternating pattern. All four numeric fields are coded as the real value minus one. The block gives a one-cycle enable pulse that marks the last input cycle of each output period, and a roughly square wave with the same period. The settings are taken in only at a clean boundary, so a change on the configuration inputs never shortens or stretches a period that has already started.

Top module: `dm_clk_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, all counters clear, `tick_o` and `wave_o` are 0 after that edge, and the first period after release is a divisor-A period of the first pattern.
- R2: With `cfg_dual` = 0, every output period is `cfg_div_a`+1 input cycles, and `cfg_rep_a`, `cfg_div_b` and `cfg_rep_b` have no effect on the output.
- R3: With `cfg_dual` = 1, the output gives `cfg_rep_a`+1 periods of `cfg_div_a`+1 cycles, then `cfg_rep_b`+1 periods of `cfg_div_b`+1 cycles, and repeats.
- R4: In dual mode one full pattern lasts exactly (`cfg_div_a`+1)·(`cfg_rep_a`+1) + (`cfg_div_b`+1)·(`cfg_rep_b`+1) input cycles.
- R5: Each field is coded minus one: a field value of 0 means 1, so a divisor field of 0 gives a period of one input cycle, with `tick_o` and `wave_o` both high in that cycle.
- R6: `tick_o` is high for exactly one input cycle per output period, in the last cycle of the period.
- R7: For a period of N ≥ 2 cycles, `wave_o` is high in the first floor(N/2) cycles and low in the rest; for N = 1 it equals `tick_o`.
- R8: The configuration inputs are taken in at the clock edge that ends a full dual pattern, or any period in single mode, and during reset; values changed at any other time take effect only from the next such edge.
- R9: The divider in use switches only at the end of a period, and in single mode divisor A is always in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_dual | input | 1 | 1 = alternate dividers A and B, 0 = divider A only |
| cfg_div_a | input | DIV_W | Divisor A minus one |
| cfg_rep_a | input | REP_W | Periods of divisor A per pattern, minus one |
| cfg_div_b | input | DIV_W | Divisor B minus one |
| cfg_rep_b | input | REP_W | Periods of divisor B per pattern, minus one |
| tick_o | output | 1 | One-cycle pulse in the last input cycle of each output period |
| wave_o | output | 1 | Roughly square divided output |

## Verification
Both outputs are registered, so the first output period begins in the first cycle after the edge that sees `rst_n` high. The bench releases reset on a falling edge and then samples every falling edge, which lets it count each period's cycles from that first sample up to and including the `tick_o` cycle. A configuration taken at the edge that ends a pattern shows up in the period that starts right after the visible tick. So the bench changes settings just after a tick and expects the old setting for the following period or pattern, and the new one after that. Reset effects are due one edge after `rst_n` falls and are sampled on the next falling edge.

// File: rtl/dm_div_pkg.sv
// Package: shared types of the dual-modulus divider.
// Assumes nothing beyond a standard SystemVerilog tool flow.
package dm_div_pkg;

    // Which of the two integer dividers is currently producing periods.
    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } div_phase_e;

endpackage

// File: rtl/dm_cfg_shadow.sv
// Module: dm_cfg_shadow
// Holds the active copy of the divider settings. The copy follows the
// configuration inputs while reset is low and whenever `load` is high.
// Assumes `load` is high only on a clean pattern boundary.
module dm_cfg_shadow #(
    parameter int DIV_W = 12,
    parameter int REP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             in_dual,
    input  logic [DIV_W-1:0] in_div_a,
    input  logic [REP_W-1:0] in_rep_a,
    input  logic [DIV_W-1:0] in_div_b,
    input  logic [REP_W-1:0] in_rep_b,
    output logic             act_dual,
    output logic [DIV_W-1:0] act_div_a,
    output logic [REP_W-1:0] act_rep_a,
    output logic [DIV_W-1:0] act_div_b,
    output logic [REP_W-1:0] act_rep_b
);

    // Capture new settings during reset or at a pattern boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            act_dual  <= in_dual;
            act_div_a <= in_div_a;
            act_rep_a <= in_rep_a;
            act_div_b <= in_div_b;
            act_rep_b <= in_rep_b;
        end
    end

endmodule

// File: rtl/dm_period_counter.sv
// Module: dm_period_counter
// Counts input cycles within one output period from 0 up to `limit`
// (the period length minus one) and makes the registered tick and wave
// outputs. Assumes `limit` stays constant within a period.
module dm_period_counter #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] limit,
    output logic             period_end,
    output logic             tick_q,
    output logic             wave_q
);

    localparam int FULL_W = DIV_W + 1;

    logic [DIV_W-1:0]  cnt_q;
    logic [FULL_W-1:0] period_len;
    logic [FULL_W-1:0] high_len;
    logic              wave_next;

    // Last cycle of the current period.
    assign period_end = (cnt_q == limit);

    // Cycles the wave spends high: floor(period / 2).
    always_comb begin
        period_len = {1'b0, limit} + FULL_W'(1);
        high_len   = period_len >> 1;
        if (limit == '0) begin
            wave_next = 1'b1;
        end else begin
            wave_next = ({1'b0, cnt_q} < high_len);
        end
    end

    // Position counter within the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (period_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // Registered outputs, low during reset so that they cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            wave_q <= 1'b0;
        end else begin
            tick_q <= period_end;
            wave_q <= wave_next;
        end
    end

endmodule

// File: rtl/dm_phase_seq.sv
// Module: dm_phase_seq
// Chooses the divider in use and counts repetitions of each one. It
// flags the end of a full pattern (dual mode) or of any period (single
// mode). Assumes `period_end` is one cycle per period.
module dm_phase_seq
    import dm_div_pkg::*;
#(
    parameter int REP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end,
    input  logic             dual,
    input  logic [REP_W-1:0] rep_a,
    input  logic [REP_W-1:0] rep_b,
    output div_phase_e       phase,
    output logic             seq_end
);

    logic [REP_W-1:0] rep_q;

    // Boundary at which a new configuration may be taken in.
    assign seq_end = period_end && (!dual || ((phase == PH_B) && (rep_q == rep_b)));

    // Repetition counting and divider selection, updated per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_A;
            rep_q <= '0;
        end else if (period_end) begin
            if (!dual) begin
                phase <= PH_A;
                rep_q <= '0;
            end else if (phase == PH_A) begin
                if (rep_q == rep_a) begin
                    phase <= PH_B;
                    rep_q <= '0;
                end else begin
                    rep_q <= rep_q + REP_W'(1);
                end
            end else begin
                if (rep_q == rep_b) begin
                    phase <= PH_A;
                    rep_q <= '0;
                end else begin
                    rep_q <= rep_q + REP_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/dm_clk_divider.sv
// Module: dm_clk_divider (top)
// Dual-modulus fractional clock divider: alternates (rep_a+1) periods
// of (div_a+1) cycles with (rep_b+1) periods of (div_b+1) cycles, or
// uses divisor A alone in single mode. Assumes one clock and a
// synchronous active-low reset.
module dm_clk_divider
    import dm_div_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int REP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dual,
    input  logic [DIV_W-1:0] cfg_div_a,
    input  logic [REP_W-1:0] cfg_rep_a,
    input  logic [DIV_W-1:0] cfg_div_b,
    input  logic [REP_W-1:0] cfg_rep_b,
    output logic             tick_o,
    output logic             wave_o
);

    logic             act_dual;
    logic [DIV_W-1:0] act_div_a;
    logic [REP_W-1:0] act_rep_a;
    logic [DIV_W-1:0] act_div_b;
    logic [REP_W-1:0] act_rep_b;
    logic [DIV_W-1:0] cur_limit;
    logic             period_end;
    logic             seq_end;
    div_phase_e       phase;

    dm_cfg_shadow #(.DIV_W(DIV_W), .REP_W(REP_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (seq_end),
        .in_dual   (cfg_dual),
        .in_div_a  (cfg_div_a),
        .in_rep_a  (cfg_rep_a),
        .in_div_b  (cfg_div_b),
        .in_rep_b  (cfg_rep_b),
        .act_dual  (act_dual),
        .act_div_a (act_div_a),
        .act_rep_a (act_rep_a),
        .act_div_b (act_div_b),
        .act_rep_b (act_rep_b)
    );

    // Period limit of the divider in use.
    assign cur_limit = (phase == PH_A) ? act_div_a : act_div_b;

    dm_period_counter #(.DIV_W(DIV_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .limit      (cur_limit),
        .period_end (period_end),
        .tick_q     (tick_o),
        .wave_q     (wave_o)
    );

    dm_phase_seq #(.REP_W(REP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_end (period_end),
        .dual       (act_dual),
        .rep_a      (act_rep_a),
        .rep_b      (act_rep_b),
        .phase      (phase),
        .seq_end    (seq_end)
    );

endmodule

// File: rtl/dm_clk_divider_chk.sv
// Module: dm_clk_divider_chk
// Checker bound to dm_clk_divider. It watches the outputs against the
// internal period limit, divider phase and active settings.
module dm_clk_divider_chk #(
    parameter int DIV_W = 12,
    parameter int REP_W = 12
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick_o,
    input logic                         wave_o,
    input logic                         period_end,
    input logic                         seq_end,
    input logic                         phase_b,
    input logic                         act_dual,
    input logic [DIV_W-1:0]             limit,
    input logic [2*DIV_W+2*REP_W:0]     act_all
);

    logic [DIV_W-1:0] len_q;
    logic             seen_q;
    logic             was_rst_q;

    // Cycles since the previous tick, and whether one has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick_o) begin
            len_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            len_q  <= len_q + DIV_W'(1);
        end
    end

    // Remembers that the previous edge was in reset.
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
    end

    // Outputs quiet right after a reset edge.
    always_ff @(posedge clk) begin
        if (was_rst_q) begin
            AST_RESET_QUIET: assert (!tick_o && !wave_o) else $error("outputs active after reset"); // R1
        end
    end

    AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && tick_o) |-> (len_q == $past(limit))) else $error("period length"); // R6

    AST_WAVE_LOW_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(rst_n) && ($past(limit) != '0)) |-> !wave_o) else $error("wave high at tick"); // R7

    AST_UNIT_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(limit) == '0)) |-> (tick_o && wave_o)) else $error("unit divisor"); // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_all) |-> ($past(seq_end) || !$past(rst_n))) else $error("config changed mid pattern"); // R8

    AST_PHASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_b) |-> $past(period_end)) else $error("divider switched mid period"); // R9

    AST_SINGLE_USES_A: assert property (@(posedge clk) disable iff (!rst_n)
        !act_dual |-> !phase_b) else $error("divider B in single mode"); // R2

endmodule

bind dm_clk_divider dm_clk_divider_chk #(.DIV_W(DIV_W), .REP_W(REP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_o     (tick_o),
    .wave_o     (wave_o),
    .period_end (period_end),
    .seq_end    (seq_end),
    .phase_b    (phase == dm_div_pkg::PH_B),
    .act_dual   (act_dual),
    .limit      (cur_limit),
    .act_all    ({act_dual, act_div_a, act_rep_a, act_div_b, act_rep_b})
);

// File: tb/test_dm_clk_divider.sv
// Bench for dm_clk_divider: a table of settings with the expected
// period pattern derived from the fields, then directed cases.
module test_dm_clk_divider;

    localparam int DIV_W = 12;
    localparam int REP_W = 12;

    typedef struct packed {
        bit              dual;
        bit [DIV_W-1:0]  da;
        bit [REP_W-1:0]  ra;
        bit [DIV_W-1:0]  db;
        bit [REP_W-1:0]  rb;
    } vec_t;

    // dual, div_a-1, rep_a-1, div_b-1, rep_b-1
    localparam vec_t VECS [5] = '{
        '{1'b0, 12'd4, 12'd3, 12'd7, 12'd2},
        '{1'b1, 12'd2, 12'd1, 12'd3, 12'd0},
        '{1'b1, 12'd0, 12'd2, 12'd1, 12'd1},
        '{1'b1, 12'd5, 12'd0, 12'd6, 12'd2},
        '{1'b0, 12'd1, 12'd0, 12'd0, 12'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_dual = 1'b0;
    logic [DIV_W-1:0] cfg_div_a = '0;
    logic [REP_W-1:0] cfg_rep_a = '0;
    logic [DIV_W-1:0] cfg_div_b = '0;
    logic [REP_W-1:0] cfg_rep_b = '0;
    logic             tick_o;
    logic             wave_o;

    int checks = 0;
    int failures = 0;
    int last_len = 0;

    always #5 clk = ~clk;

    dm_clk_divider #(.DIV_W(DIV_W), .REP_W(REP_W)) i_dm_clk_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_dual  (cfg_dual),
        .cfg_div_a (cfg_div_a),
        .cfg_rep_a (cfg_rep_a),
        .cfg_div_b (cfg_div_b),
        .cfg_rep_b (cfg_rep_b),
        .tick_o    (tick_o),
        .wave_o    (wave_o)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cfg_dual  = v.dual;
        cfg_div_a = v.da;
        cfg_rep_a = v.ra;
        cfg_div_b = v.db;
        cfg_rep_b = v.rb;
    endtask

    // Reset with a setting applied; check quiet outputs; release on negedge.
    task automatic do_reset(input vec_t v);
        @(negedge clk);
        rst_n = 1'b0;
        apply(v);
        repeat (3) @(negedge clk);
        check(!tick_o && !wave_o, "R1", int'({tick_o, wave_o}), 0);
        rst_n = 1'b1;
    endtask

    // Measure one period up to and including its tick.
    task automatic measure(input int exp_len, input string req);
        int  len = 0;
        int  hi = 0;
        bit  got = 0;
        bit  seen_low = 0;
        bit  prefix_ok = 1;
        int  exp_hi;
        while (!got && len < 5000) begin
            @(negedge clk);
            len++;
            if (wave_o) begin
                hi++;
                if (seen_low) prefix_ok = 0;
            end else begin
                seen_low = 1;
            end
            if (tick_o) got = 1;
        end
        last_len = len;
        check(len == exp_len, req, len, exp_len);
        exp_hi = (exp_len >= 2) ? exp_len / 2 : 1;
        check((hi == exp_hi) && prefix_ok, "R7 wave high cycles", hi, exp_hi);
    endtask

    // Measure one full pattern of a setting and check its total length.
    task automatic run_pattern(input vec_t v);
        int total = 0;
        int exp_total;
        if (!v.dual) begin
            measure(int'(v.da) + 1, "R2 single period");
            total = last_len;
        end else begin
            for (int i = 0; i <= int'(v.ra); i++) begin
                measure(int'(v.da) + 1, "R3 R6 divider A period");
                total += last_len;
            end
            for (int i = 0; i <= int'(v.rb); i++) begin
                measure(int'(v.db) + 1, "R3 R6 divider B period");
                total += last_len;
            end
            exp_total = (int'(v.da) + 1) * (int'(v.ra) + 1) + (int'(v.db) + 1) * (int'(v.rb) + 1);
            check(total == exp_total, "R4 pattern length", total, exp_total);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        vec_t v;
        // Table walk: two patterns per setting, each from reset.
        for (int k = 0; k < 5; k++) begin
            do_reset(VECS[k]);
            run_pattern(VECS[k]);
            run_pattern(VECS[k]);
        end

        // R5: unit divisor in single mode gives a tick every cycle.
        v = '{1'b0, 12'd0, 12'd5, 12'd9, 12'd9};
        do_reset(v);
        for (int i = 0; i < 4; i++) measure(1, "R5 unit period");

        // R8 single: change after a visible tick; next period keeps old value.
        v = '{1'b0, 12'd4, 12'd0, 12'd0, 12'd0};
        do_reset(v);
        measure(5, "R2 single period");
        v.da = 12'd2;
        apply(v);
        measure(5, "R8 old setting kept");
        measure(3, "R8 new setting taken");

        // R8 dual: change mid pattern; pattern 3,3,4 finishes, then single 4.
        v = '{1'b1, 12'd2, 12'd1, 12'd3, 12'd0};
        do_reset(v);
        measure(3, "R3 divider A period");
        v = '{1'b0, 12'd3, 12'd0, 12'd0, 12'd0};
        apply(v);
        measure(3, "R8 old pattern A");
        measure(4, "R8 old pattern B");
        measure(4, "R8 new single period");
        measure(4, "R8 R9 single stays on A");

        // R1: reset in the middle of a period, then restart at divider A.
        v = '{1'b1, 12'd5, 12'd0, 12'd2, 12'd0};
        do_reset(v);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!tick_o && !wave_o, "R1 mid-run reset", int'({tick_o, wave_o}), 0);
        rst_n = 1'b1;
        measure(6, "R1 restart on divider A");
        measure(3, "R3 divider B after restart");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule